// File: doc/BRIEF.md
# Dual-Channel Console Serial Port Register Front End

This block sits between a host CPU's register bus and two byte-wide serial channels, a console channel (A) and an auxiliary channel (B). For each channel it presents a status register, a command register and a holding register that serves both receive and transmit. Both channels share an interrupt status register, an interrupt mask register and one interrupt line. Received characters arrive on a valid/ready byte stream per channel. Transmitted characters leave as a one-cycle strobe with the data byte.

The transmit side is always reported as ready. Transmit-ready interrupts follow a periodic tick input, not the state of a real buffer: every second tick injects them when either transmit mask bit is enabled. The interrupt line is a latched level. Any enabled event sets it. Only a read of the channel A status register drops it.

Baud generation, framing, mode registers and timers are not modelled. Writes to their offsets have no effect.

Top module: `con_uart_front`

## Requirements
- R1: After reset the interrupt status and the interrupt mask are zero, the interrupt line is low and a read of the interrupt register returns 0x00.
- R2: A read of a channel status register returns bit 2 = 1 (transmit ready) at all times, bit 0 = 1 while that channel's receive stream holds a valid character, and all other bits 0.
- R3: At offset 0x42C a write loads the 8-bit interrupt mask and a read returns the interrupt status. Bit 0 is TX-ready A, bit 1 is RX-ready A, bit 4 is TX-ready B and bit 5 is RX-ready B. Every other status bit reads 0.
- R4: A new character on a channel whose RX-ready mask bit (1 for A, 5 for B) is set sets that channel's RX-ready status bit and raises the interrupt line on the next clock. With the mask bit clear, neither changes. When a set and a clear hit the same status bit in one cycle, the set wins.
- R5: A read of a channel holding register returns the waiting character, or 0x00 if none is waiting. It pops the receive stream (ready asserted for that cycle) and clears that channel's RX-ready status bit.
- R6: A write to either holding register emits the byte on that channel's transmit strobe and clears the TX-ready A status bit (bit 0). A write to the channel B holding register leaves bit 4 unchanged.
- R7: A tick counter advances on each tick pulse and wraps on every second tick. On the wrap, if mask bit 0 or bit 4 is set, status bits 0 and 4 are both set and the interrupt line is raised. On other ticks, or with both bits clear, nothing changes.
- R8: A read of the channel A status register drops the interrupt line on the next clock unless an interrupt event occurs in the same cycle. Reads of the channel B status register and clears of status bits leave the line unchanged.
- R9: A write to a channel command register with bit 3 set pulses that channel's flush output for exactly that cycle. A write with bit 3 clear produces no pulse.
- R10: Reads from unmapped offsets and from the command registers return 0x00. Writes to any offset other than the interrupt register, the command registers and the holding registers change no state.
- R11: The registers sit at these offsets: status A 0x40C, command A 0x414, holding A 0x41C, interrupt 0x42C, status B 0x44C, command B 0x454, holding B 0x45C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| tick | input | 1 | Periodic tick pulse |
| rx_valid_a | input | 1 | Channel A receive character valid |
| rx_data_a | input | 8 | Channel A receive character |
| rx_ready_a | output | 1 | Channel A receive pop |
| rx_valid_b | input | 1 | Channel B receive character valid |
| rx_data_b | input | 8 | Channel B receive character |
| rx_ready_b | output | 1 | Channel B receive pop |
| tx_strobe_a | output | 1 | Channel A transmit byte strobe |
| tx_data_a | output | 8 | Channel A transmit byte |
| tx_strobe_b | output | 1 | Channel B transmit byte strobe |
| tx_data_b | output | 8 | Channel B transmit byte |
| flush_a | output | 1 | Channel A flush request pulse |
| flush_b | output | 1 | Channel B flush request pulse |
| irq | output | 1 | Shared interrupt line |

## Verification
The bench targets the channel B holding write. A design that cleared bit 4 instead of bit 0 would read back 0x01 where 0x10 is expected. It checks that the interrupt line survives a channel B status read and status-bit clears. A design that dropped the line on any status read or on an empty status would show irq low too early. Tick pairs are run both with the transmit masks off and with only the B transmit mask on. Wrapping on every tick, or gating on the wrong mask bit, shows up as a wrong status byte. Writes to ignored offsets are followed by a masked character arrival, so a stray write into the mask would raise the line.

// File: rtl/con_uart_pkg.sv
package con_uart_pkg;

  localparam int NCHAN = 2;

  // register kinds inside a channel's window
  localparam int KIND_STAT = 0;
  localparam int KIND_CMD  = 1;
  localparam int KIND_HOLD = 2;

  localparam int CHAN_BASE   = 'h40C;
  localparam int KIND_STRIDE = 'h8;
  localparam int CHAN_STRIDE = 'h40;
  localparam int OFS_INTREG  = 'h42C;

  // interrupt status / mask bit positions
  localparam int IB_TXA = 0;
  localparam int IB_RXA = 1;
  localparam int IB_TXB = 4;
  localparam int IB_RXB = 5;

  // status and command bit positions
  localparam int SB_RXAV  = 0;
  localparam int SB_TXRDY = 2;
  localparam int CB_TXOFF = 3;

  function automatic int reg_ofs(input int ch, input int kind);
    return CHAN_BASE + kind * KIND_STRIDE + ch * CHAN_STRIDE;
  endfunction

  function automatic logic [7:0] status_byte(input logic rx_avail);
    logic [7:0] s;
    s = '0;
    s[SB_TXRDY] = 1'b1;
    s[SB_RXAV]  = rx_avail;
    return s;
  endfunction

  function automatic int rx_bit(input int ch);
    return (ch == 0) ? IB_RXA : IB_RXB;
  endfunction

  function automatic logic [7:0] isr_next(input logic [7:0] cur,
                                          input logic [7:0] sets,
                                          input logic [7:0] clrs);
    return (cur & ~clrs) | sets;
  endfunction

endpackage

// File: rtl/cu_decode.sv
module cu_decode
  import con_uart_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCHAN-1:0]  rd_stat,
  output logic [NCHAN-1:0]  wr_cmd,
  output logic [NCHAN-1:0]  rd_hold,
  output logic [NCHAN-1:0]  wr_hold,
  output logic              rd_int,
  output logic              wr_int
);

  logic rd_cyc, wr_cyc;
  assign rd_cyc = sel & ~wr;
  assign wr_cyc = sel & wr;

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    assign rd_stat[c] = rd_cyc && (addr == ADDR_W'(reg_ofs(c, KIND_STAT)));
    assign wr_cmd[c]  = wr_cyc && (addr == ADDR_W'(reg_ofs(c, KIND_CMD)));
    assign rd_hold[c] = rd_cyc && (addr == ADDR_W'(reg_ofs(c, KIND_HOLD)));
    assign wr_hold[c] = wr_cyc && (addr == ADDR_W'(reg_ofs(c, KIND_HOLD)));
  end

  assign rd_int = rd_cyc && (addr == ADDR_W'(OFS_INTREG));
  assign wr_int = wr_cyc && (addr == ADDR_W'(OFS_INTREG));

endmodule

// File: rtl/cu_chan.sv
module cu_chan
  import con_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rd_hold,
  input  logic              wr_hold,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic              arrival,
  output logic              tx_strobe,
  output logic [DATA_W-1:0] tx_data,
  output logic              flush,
  output logic [DATA_W-1:0] stat_byte,
  output logic [DATA_W-1:0] hold_byte
);

  // seen_q marks that the character now on the stream was already announced
  logic seen_q;

  assign rx_ready  = rd_hold & rx_valid;
  assign arrival   = rx_valid & ~seen_q;
  assign tx_strobe = wr_hold;
  assign tx_data   = wdata;
  assign flush     = wr_cmd & wdata[CB_TXOFF];
  assign stat_byte = DATA_W'(status_byte(rx_valid));
  assign hold_byte = rx_valid ? rx_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= rx_valid & ~rx_ready;
  end

  // R4: a character that stays on the stream is announced once only
  a_r4_single_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    (arrival && !rx_ready) |=> !arrival);

endmodule

// File: rtl/cu_irq.sv
module cu_irq
  import con_uart_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_int,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCHAN-1:0]  arrival,
  input  logic [NCHAN-1:0]  rd_hold,
  input  logic [NCHAN-1:0]  wr_hold,
  input  logic              rd_stat_a,
  output logic [DATA_W-1:0] isr,
  output logic              irq
);

  localparam int SEQ_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [SEQ_W-1:0]  seq_q;
  logic [DATA_W-1:0] mask_q, isr_q;
  logic              irq_q;
  logic              wrap, tx_fire, set_any;
  logic [7:0]        set_v, clr_v;

  assign wrap    = tick && (seq_q == SEQ_W'(TICK_DIV - 1));
  assign tx_fire = wrap && (mask_q[IB_TXA] || mask_q[IB_TXB]);

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int c = 0; c < NCHAN; c++) begin
      if (arrival[c] && mask_q[rx_bit(c)]) set_v[rx_bit(c)] = 1'b1;
      if (rd_hold[c]) clr_v[rx_bit(c)] = 1'b1;
    end
    if (tx_fire) begin
      set_v[IB_TXA] = 1'b1;
      set_v[IB_TXB] = 1'b1;
    end
    // either holding write clears the channel A transmit bit
    if (|wr_hold) clr_v[IB_TXA] = 1'b1;
  end

  assign set_any = |set_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= '0;
      mask_q <= '0;
      isr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (tick) seq_q <= wrap ? '0 : seq_q + 1'b1;
      if (wr_int) mask_q <= wdata;
      isr_q <= DATA_W'(isr_next(isr_q[7:0], set_v, clr_v));
      if (set_any)        irq_q <= 1'b1;
      else if (rd_stat_a) irq_q <= 1'b0;
    end
  end

  assign isr = isr_q;
  assign irq = irq_q;

  a_r4_rx_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (arrival[0] && mask_q[IB_RXA]) |=> (irq && isr[IB_RXA]));

  a_r5_hold_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hold[0] && !set_v[IB_RXA]) |=> !isr[IB_RXA]);

  a_r6_b_write_keeps_txb: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold[1] && !tx_fire) |=> (isr[IB_TXB] == $past(isr[IB_TXB])));

  a_r7_wrap_sets_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (isr[IB_TXA] && isr[IB_TXB] && irq));

  a_r8_stat_a_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_a && !set_any) |=> !irq);

endmodule

// File: rtl/con_uart_front.sv
module con_uart_front
  import con_uart_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic              rx_valid_a,
  input  logic [DATA_W-1:0] rx_data_a,
  output logic              rx_ready_a,
  input  logic              rx_valid_b,
  input  logic [DATA_W-1:0] rx_data_b,
  output logic              rx_ready_b,
  output logic              tx_strobe_a,
  output logic [DATA_W-1:0] tx_data_a,
  output logic              tx_strobe_b,
  output logic [DATA_W-1:0] tx_data_b,
  output logic              flush_a,
  output logic              flush_b,
  output logic              irq
);

  logic [NCHAN-1:0]  rd_stat, wr_cmd, rd_hold, wr_hold;
  logic              rd_int, wr_int;
  logic [NCHAN-1:0]  rx_valid_v, rx_ready_v, arrival_v, tx_strobe_v, flush_v;
  logic [DATA_W-1:0] rx_data_v   [NCHAN];
  logic [DATA_W-1:0] tx_data_v   [NCHAN];
  logic [DATA_W-1:0] stat_byte_v [NCHAN];
  logic [DATA_W-1:0] hold_byte_v [NCHAN];
  logic [DATA_W-1:0] isr;

  assign rx_valid_v   = {rx_valid_b, rx_valid_a};
  assign rx_data_v[0] = rx_data_a;
  assign rx_data_v[1] = rx_data_b;

  cu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .rd_stat(rd_stat), .wr_cmd(wr_cmd), .rd_hold(rd_hold), .wr_hold(wr_hold),
    .rd_int(rd_int), .wr_int(wr_int)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    cu_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid_v[c]), .rx_data(rx_data_v[c]), .rx_ready(rx_ready_v[c]),
      .rd_hold(rd_hold[c]), .wr_hold(wr_hold[c]), .wr_cmd(wr_cmd[c]),
      .wdata(bus_wdata), .arrival(arrival_v[c]),
      .tx_strobe(tx_strobe_v[c]), .tx_data(tx_data_v[c]), .flush(flush_v[c]),
      .stat_byte(stat_byte_v[c]), .hold_byte(hold_byte_v[c])
    );
  end

  cu_irq #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_irq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_int(wr_int), .wdata(bus_wdata),
    .arrival(arrival_v), .rd_hold(rd_hold), .wr_hold(wr_hold),
    .rd_stat_a(rd_stat[0]), .isr(isr), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_int) bus_rdata = isr;
    for (int c = 0; c < NCHAN; c++) begin
      if (rd_stat[c]) bus_rdata = stat_byte_v[c];
      if (rd_hold[c]) bus_rdata = hold_byte_v[c];
    end
  end

  assign rx_ready_a  = rx_ready_v[0];
  assign rx_ready_b  = rx_ready_v[1];
  assign tx_strobe_a = tx_strobe_v[0];
  assign tx_strobe_b = tx_strobe_v[1];
  assign tx_data_a   = tx_data_v[0];
  assign tx_data_b   = tx_data_v[1];
  assign flush_a     = flush_v[0];
  assign flush_b     = flush_v[1];

  // R9: a flush pulse only ever accompanies a bus write
  a_r9_flush_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_a || flush_b) |-> (bus_sel && bus_wr));

  // R1: the interrupt line starts low
  a_r1_irq_low_after_reset: assert property (@(posedge clk)
    !rst_n |=> !irq);

endmodule

// File: tb/sim_con_uart_front.sv
`timescale 1ns/1ps
module sim_con_uart_front;

  localparam logic [11:0] A_STAT_A = 12'h40C, A_CMD_A = 12'h414, A_HOLD_A = 12'h41C;
  localparam logic [11:0] A_INT    = 12'h42C;
  localparam logic [11:0] A_STAT_B = 12'h44C, A_CMD_B = 12'h454, A_HOLD_B = 12'h45C;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, tick = 0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic rx_valid_a = 0, rx_valid_b = 0, rx_ready_a, rx_ready_b;
  logic [7:0] rx_data_a = '0, rx_data_b = '0, tx_data_a, tx_data_b;
  logic tx_strobe_a, tx_strobe_b, flush_a, flush_b, irq;

  always #4 clk = ~clk;

  con_uart_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick),
    .rx_valid_a(rx_valid_a), .rx_data_a(rx_data_a), .rx_ready_a(rx_ready_a),
    .rx_valid_b(rx_valid_b), .rx_data_b(rx_data_b), .rx_ready_b(rx_ready_b),
    .tx_strobe_a(tx_strobe_a), .tx_data_a(tx_data_a),
    .tx_strobe_b(tx_strobe_b), .tx_data_b(tx_data_b),
    .flush_a(flush_a), .flush_b(flush_b), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int n_txa = 0, n_txb = 0, n_fla = 0, n_flb = 0, n_popa = 0, n_popb = 0;
  logic [7:0] last_txa = '0, last_txb = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each bus read with the queued expectation
  always @(negedge clk) begin
    #2;
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) chk("scoreboard underrun", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    if (tx_strobe_a) begin n_txa++; last_txa = tx_data_a; end
    if (tx_strobe_b) begin n_txb++; last_txb = tx_data_b; end
    if (flush_a) n_fla++;
    if (flush_b) n_flb++;
    if (rx_ready_a) n_popa++;
    if (rx_ready_b) n_popb++;
  end

  task automatic idle_after_edge();
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; tick = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    idle_after_edge();
    if (a == A_HOLD_A && rx_ready_a === 1'b0) ; // nothing
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    idle_after_edge();
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    idle_after_edge();
  endtask

  task automatic put_a(input logic [7:0] d);
    @(negedge clk); rx_valid_a = 1; rx_data_a = d;
    @(posedge clk); #1;
  endtask

  task automatic put_b(input logic [7:0] d);
    @(negedge clk); rx_valid_b = 1; rx_data_b = d;
    @(posedge clk); #1;
  endtask

  // holding read that also retires the character from the bench's source
  task automatic pop_a(input logic [7:0] exp, input string tag);
    rd(A_HOLD_A, exp, tag); rx_valid_a = 0;
  endtask

  task automatic pop_b(input logic [7:0] exp, input string tag);
    rd(A_HOLD_B, exp, tag); rx_valid_b = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    rd(A_INT, 8'h00, "R1 isr after reset");
    rd(A_STAT_A, 8'h04, "R2 R11 status A idle");
    rd(A_STAT_B, 8'h04, "R2 R11 status B idle");
    rd(A_HOLD_A, 8'h00, "R5 empty holding read");
    rd(12'h404, 8'h00, "R10 unmapped read");
    rd(A_CMD_A, 8'h00, "R10 command read");

    // R7 ticks with only RX masks set: nothing happens
    wr(A_INT, 8'h22);
    pulse_tick(); pulse_tick();
    rd(A_INT, 8'h00, "R7 tick without tx mask");
    chk("R7 irq without tx mask", irq, 0);

    // R4 channel A arrival with mask set
    put_a(8'h5A);
    chk("R4 irq on rx A", irq, 1);
    rd(A_INT, 8'h02, "R3 R4 isr rx A");
    rd(A_STAT_A, 8'h05, "R2 status A with char");
    chk("R8 status A read drops irq", irq, 0);
    pop_a(8'h5A, "R5 holding A data");
    chk("R5 pop A", n_popa, 1);
    rd(A_INT, 8'h00, "R5 rx A bit cleared");
    rd(A_STAT_A, 8'h04, "R2 status A after pop");

    // R4/R8 channel B
    put_b(8'hC3);
    chk("R4 irq on rx B", irq, 1);
    rd(A_INT, 8'h20, "R3 R4 isr rx B");
    rd(A_STAT_B, 8'h05, "R2 R11 status B with char");
    chk("R8 status B read keeps irq", irq, 1);
    pop_b(8'hC3, "R5 holding B data");
    chk("R5 pop B", n_popb, 1);
    rd(A_INT, 8'h00, "R5 rx B bit cleared");
    chk("R8 isr clear keeps irq", irq, 1);
    rd(A_STAT_A, 8'h04, "R2 status A");
    chk("R8 status A read drops irq", irq, 0);

    // R4 masked arrival
    wr(A_INT, 8'h00);
    put_a(8'h11);
    chk("R4 masked rx no irq", irq, 0);
    rd(A_INT, 8'h00, "R4 masked rx no isr");
    rd(A_STAT_A, 8'h05, "R2 masked char visible");
    pop_a(8'h11, "R5 holding A masked data");

    // R7 tick pair with TX A mask
    wr(A_INT, 8'h01);
    pulse_tick();
    rd(A_INT, 8'h00, "R7 first tick no effect");
    pulse_tick();
    rd(A_INT, 8'h11, "R7 second tick sets both tx");
    chk("R7 irq on tick wrap", irq, 1);

    // R6 holding writes
    wr(A_HOLD_A, 8'h41);
    chk("R6 tx A strobe count", n_txa, 1);
    chk("R6 tx A data", last_txa, 8'h41);
    rd(A_INT, 8'h10, "R6 write A clears tx A");
    rd(A_STAT_A, 8'h04, "R2 status A tx ready");
    wr(A_INT, 8'h10);
    pulse_tick(); pulse_tick();
    rd(A_INT, 8'h11, "R7 tx B mask alone fires");
    wr(A_HOLD_B, 8'h42);
    chk("R6 tx B strobe count", n_txb, 1);
    chk("R6 tx B data", last_txb, 8'h42);
    chk("R6 no stray tx A", n_txa, 1);
    rd(A_INT, 8'h10, "R6 write B clears tx A not tx B");

    // R9 flush
    wr(A_CMD_A, 8'h08);
    chk("R9 flush A", n_fla, 1);
    wr(A_CMD_A, 8'h07);
    chk("R9 no flush without bit3", n_fla, 1);
    wr(A_CMD_B, 8'h0F);
    chk("R9 flush B", n_flb, 1);
    chk("R9 flush B leaves A", n_fla, 1);

    // R10 ignored writes do not reach the mask
    rd(A_STAT_A, 8'h04, "R2 status A");
    wr(A_INT, 8'h00);
    wr(12'h404, 8'hFF);
    wr(12'h424, 8'hFF);
    wr(12'h434, 8'hFF);
    put_a(8'h77);
    chk("R10 ignored writes leave mask", irq, 0);
    rd(A_INT, 8'h10, "R10 isr unchanged");
    pop_a(8'h77, "R5 holding A after ignored writes");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule